// File: doc/BRIEF.md
# Always-On Bus-Serviced Watchdog Reset Generator

This block is a watchdog that cannot be switched off. It counts clock cycles through a prescaler followed by a main counter. If software does not service it before the chain reaches its terminal count, the block raises an internal reset request for the rest of the controller. To service it, software writes a data word with bit 0 cleared to one fixed bus address. A write with bit 0 set, a write to any other address, or a cycle without a write strobe leaves the count running.

The reset request is held for a fixed number of cycles. While it is active the counter stays at zero and bus writes have no effect. When the pulse ends, counting starts again from zero.

Only the power-on reset input clears the block's state. The watchdog's own reset does not clear it. The operating-mode value is sampled from the strap input once, on the first clock after power-on reset is released, and is kept through every watchdog reset. A sticky status flag records that a watchdog timeout has happened, and only power-on reset clears it.

Top module: `cop_watchdog`

## Requirements
- R1: A write to SVC_ADDR (default 14'h3FF0) with `bus_we` high and `bus_wdata[0]` equal to 0, made outside a reset pulse, clears the prescaler and the counter. The next timeout then comes no earlier than 2^(PRE_W+CNT_W) cycles later.
- R2: A write whose bit 0 is 1, a write to any other address, or `bus_wdata` with `bus_we` low does not change the count.
- R3: Without service, `wdog_rst` rises on the edge that ends the 2^(PRE_W+CNT_W)-th counted cycle after the last clear. No input can disable this.
- R4: Each `wdog_rst` pulse is high for exactly RST_LEN (default 4) clock cycles.
- R5: While `wdog_rst` is high, the count stays at zero and service writes are ignored. The next timeout follows 2^(PRE_W+CNT_W) cycles after the pulse ends.
- R6: With no service at all, pulses repeat with a period of 2^(PRE_W+CNT_W)+RST_LEN cycles.
- R7: `mode_q` takes `mode_strap` on the first clock after `por_n` is released and then holds that value through watchdog resets, whatever the strap does later.
- R8: `wdog_flag` goes high on the same edge that starts a reset pulse and stays high until power-on reset.
- R9: While `por_n` is low, `wdog_rst` and `wdog_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| bus_addr | input | ADDR_W | Write address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data; only bit 0 is used |
| mode_strap | input | MODE_W | Mode value, sampled once after power-on |
| wdog_rst | output | 1 | Internal reset request pulse |
| wdog_flag | output | 1 | Sticky flag: a watchdog timeout has occurred |
| mode_q | output | MODE_W | Retained operating mode |

## Verification
The assertions assume that bus inputs are stable at each rising edge and that `por_n` is the only thing that resets the block. The timing properties also assume that a service write is only counted outside a pulse, which matches how the block treats such writes. The stimulus drives every input on the falling edge. Random traffic mixes real service writes with writes that have bit 0 set, writes to a neighbouring address and idle cycles, so that some stretches reach a timeout and others do not. The strap input changes only at chosen moments, to show that a later change is not taken up.

// File: rtl/cop_watchdog.sv
module cop_watchdog #(
  parameter int ADDR_W  = 14,
  parameter int DATA_W  = 8,
  parameter int MODE_W  = 2,
  parameter int PRE_W   = 8,
  parameter int CNT_W   = 8,
  parameter int RST_LEN = 4,
  parameter logic [ADDR_W-1:0] SVC_ADDR = 14'h3FF0
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [MODE_W-1:0] mode_strap,
  output logic              wdog_rst,
  output logic              wdog_flag,
  output logic [MODE_W-1:0] mode_q
);
  localparam int RL_W = $clog2(RST_LEN + 1);

  logic [PRE_W-1:0]  pre_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [RL_W-1:0]   pulse_q;
  logic              flag_q;
  logic              strap_done_q;
  logic [MODE_W-1:0] mode_r;

  wire unused_wdata = ^bus_wdata[DATA_W-1:1];

  wire in_pulse = pulse_q != '0;
  wire svc      = bus_we && (bus_addr == SVC_ADDR) && !bus_wdata[0] && !in_pulse;
  wire pre_wrap = &pre_q;
  wire expire   = pre_wrap && (&cnt_q) && !svc && !in_pulse;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (in_pulse || svc || expire) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      pre_q <= pre_q + 1'b1;
      if (pre_wrap) cnt_q <= cnt_q + 1'b1;
    end

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)        pulse_q <= '0;
    else if (expire)   pulse_q <= RL_W'(RST_LEN);
    else if (in_pulse) pulse_q <= pulse_q - 1'b1;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)      flag_q <= 1'b0;
    else if (expire) flag_q <= 1'b1;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      mode_r       <= '0;
      strap_done_q <= 1'b0;
    end else if (!strap_done_q) begin
      mode_r       <= mode_strap;
      strap_done_q <= 1'b1;
    end

  assign wdog_rst  = in_pulse;
  assign wdog_flag = flag_q;
  assign mode_q    = mode_r;
endmodule

// File: rtl/cop_watchdog_chk.sv
module cop_watchdog_chk #(
  parameter int ADDR_W  = 14,
  parameter int DATA_W  = 8,
  parameter int MODE_W  = 2,
  parameter int PRE_W   = 8,
  parameter int CNT_W   = 8,
  parameter int RST_LEN = 4,
  parameter logic [ADDR_W-1:0] SVC_ADDR = 14'h3FF0
) (
  input logic              clk,
  input logic              por_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              wdog_rst,
  input logic              wdog_flag,
  input logic [MODE_W-1:0] mode_q
);
  localparam int TOT_W = PRE_W + CNT_W;
  localparam logic [TOT_W:0] PERIOD = {1'b1, {TOT_W{1'b0}}};

  logic [TOT_W:0] idle;
  logic [31:0]    plen;
  logic           seen;

  wire svc_req = bus_we && (bus_addr == SVC_ADDR) && !bus_wdata[0];

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      idle <= '0;
      plen <= '0;
      seen <= 1'b0;
    end else begin
      idle <= (wdog_rst || svc_req) ? '0 : idle + 1'b1;
      plen <= wdog_rst ? plen + 1 : '0;
      seen <= 1'b1;
    end

  AST_SVC_HOLDS_OFF: assert property (@(posedge clk) disable iff (!por_n)
    (svc_req && !wdog_rst) |=> !wdog_rst);                                     // R1
  AST_TIMEOUT_EXACT: assert property (@(posedge clk) disable iff (!por_n)
    $rose(wdog_rst) |-> idle == PERIOD);                                       // R3
  AST_NO_LATE: assert property (@(posedge clk) disable iff (!por_n)
    !wdog_rst |-> idle < PERIOD);                                              // R3
  AST_PULSE_LEN: assert property (@(posedge clk) disable iff (!por_n)
    $fell(wdog_rst) |-> plen == RST_LEN);                                      // R4
  AST_PULSE_MAX: assert property (@(posedge clk) disable iff (!por_n)
    wdog_rst |-> plen < RST_LEN);                                              // R4
  AST_MODE_KEPT: assert property (@(posedge clk) disable iff (!por_n)
    seen |=> $stable(mode_q));                                                 // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    wdog_flag |=> wdog_flag);                                                  // R8
  AST_FLAG_WITH_RST: assert property (@(posedge clk) disable iff (!por_n)
    $rose(wdog_rst) |-> wdog_flag);                                            // R8
endmodule

bind cop_watchdog cop_watchdog_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MODE_W(MODE_W), .PRE_W(PRE_W),
  .CNT_W(CNT_W), .RST_LEN(RST_LEN), .SVC_ADDR(SVC_ADDR)
) u_chk (
  .clk(clk), .por_n(por_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .wdog_rst(wdog_rst), .wdog_flag(wdog_flag),
  .mode_q(mode_q)
);

// File: tb/tb_cop_watchdog.sv
module tb_cop_watchdog;
  localparam int PRE_W = 3, CNT_W = 3, RST_LEN = 4;
  localparam logic [13:0] SVC = 14'h3FF0;
  localparam int TMAX = (1 << (PRE_W + CNT_W)) - 1;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic [13:0] bus_addr = '0;
  logic bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [1:0] mode_strap = 2'd2;
  logic wdog_rst, wdog_flag;
  logic [1:0] mode_q;

  int nvec = 0, nbad = 0, pulses = 0;
  int m_c = 0, m_r = 0;
  bit m_flag = 0, m_done = 0;
  logic [1:0] m_mode = '0;

  always #2 clk = ~clk;

  cop_watchdog #(.PRE_W(PRE_W), .CNT_W(CNT_W), .RST_LEN(RST_LEN)) dut (
    .clk(clk), .por_n(por_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .mode_strap(mode_strap), .wdog_rst(wdog_rst),
    .wdog_flag(wdog_flag), .mode_q(mode_q));

  function automatic bit is_svc(logic [13:0] a, logic we, logic [7:0] d);
    return we && (a == SVC) && !d[0];
  endfunction

  task automatic model_edge(bit svc);
    if (!m_done) begin m_mode = mode_strap; m_done = 1; end
    if (m_r != 0) begin m_r--; m_c = 0; end
    else if (svc) m_c = 0;
    else if (m_c == TMAX) begin m_r = RST_LEN; m_c = 0; m_flag = 1; pulses++; end
    else m_c++;
  endtask

  task automatic check(string tag);
    nvec++;
    if (wdog_rst !== (m_r != 0) || wdog_flag !== m_flag ||
        (m_done && mode_q !== m_mode)) begin
      nbad++;
      $display("FAIL %s rst/flag/mode act=%b/%b/%0d exp=%b/%b/%0d", tag,
               wdog_rst, wdog_flag, mode_q, (m_r != 0), m_flag, m_mode);
    end
  endtask

  task automatic step(logic [13:0] a, logic we, logic [7:0] d, string tag);
    bus_addr = a; bus_we = we; bus_wdata = d;
    @(posedge clk);
    model_edge(is_svc(a, we, d));
    @(negedge clk);
    check(tag);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(14'h0, 1'b0, 8'h0, tag);
  endtask

  task automatic por(logic [1:0] strap);
    @(negedge clk);
    por_n = 1'b0;
    m_c = 0; m_r = 0; m_flag = 0; m_done = 0;
    #1 check("R9");
    @(negedge clk);
    check("R9");
    mode_strap = strap;
    por_n = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    int p0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R9");
    por(2'd2);
    idle(TMAX + 12, "R3");
    idle(2, "R4");
    mode_strap = 2'd1;
    idle(TMAX + RST_LEN + 3, "R7");
    p0 = pulses;
    for (int i = 0; i < 2 * TMAX; i++) step(SVC, 1'b1, 8'hFF, "R2");
    for (int i = 0; i < TMAX; i++) step(SVC + 14'd1, 1'b1, 8'h00, "R2");
    nvec++;
    if (pulses - p0 < 2) begin
      nbad++;
      $display("FAIL R2 pulses act=%0d exp>=2", pulses - p0);
    end
    while (m_r == 0) idle(1, "R5");
    while (m_r != 0) step(SVC, 1'b1, 8'h00, "R5");
    p0 = pulses;
    for (int k = 0; k < 5; k++) begin
      idle(TMAX, "R1");
      step(SVC, 1'b1, 8'hFE, "R1");
    end
    nvec++;
    if (pulses != p0) begin
      nbad++;
      $display("FAIL R1 pulses act=%0d exp=0", pulses - p0);
    end
    idle(3 * (TMAX + 1 + RST_LEN) + 5, "R6");
    por(2'd3);
    idle(5, "R8");
    for (int i = 0; i < 4000; i++) begin
      logic [13:0] a;
      logic we;
      logic [7:0] d;
      a  = ($urandom % 4 == 0) ? SVC + 14'($urandom % 2) : 14'($urandom);
      we = ($urandom % 16) == 0;
      d  = 8'($urandom);
      step(a, we, d, "R1");
    end
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule